// File: doc/BRIEF.md
# Interrupt Pending Latch Bank

This block holds the pending state of a bank of interrupt lines inside an interrupt distributor. Each line runs in level mode or edge mode. A line becomes pending from its input, or because software asked for it through a set-pending write port. The per-line enable does not decide whether pending is recorded. It only gates whether a pending line is passed on to the CPU-interface forwarding stage, and a global distributor enable gates that stage as a whole.

Every line keeps two separate records. One is a software latch, set by the set-pending port. The other is a hardware term: the sampled input level for a level-mode line, or an edge-captured bit for an edge-mode line. Because the two are kept apart, a level-mode line that software made pending stays pending when its input falls. The pending-status output is the combination of the two records. Configuration (per-line enable, per-line mode, global enable) is written through a small selector port and can be read back.

Top module: `irq_pend_bank`

## Requirements
- R1: Reset state. After reset, every software latch, edge-captured bit and enable bit is 0. Every line is in level mode (mode bit 0). The global enable is 0, and `pend_rd` and `fwd_out` read all zeros.
- R2: Rising edge. The inputs are sampled every clock. A rising edge is a previous sample of 0 followed by a current sample of 1. On an edge-mode line, a rising edge sets that line's pending state whether or not the line is enabled.
- R3: Level mode read-back. On a level-mode line, `pend_rd` is the OR of the software latch and the sampled input level. With no software latch set, pending clears once the input falls.
- R4: Software hold. A level-mode line set through the set-pending port stays pending after its input falls, until a clear-pending write hits it.
- R5: Clear-pending. A 1 in `clr_mask` with `clr_we` clears that line's software latch and its edge-captured bit. A level-mode line whose input is still high stays pending.
- R6: Zero bits ignored. Bits that are 0 in `set_mask` or `clr_mask` leave the pending state of those lines unchanged.
- R7: Set wins. When a set-pending write and a clear-pending write hit the same bit in the same cycle, the line ends up pending.
- R8: Forwarding. `fwd_out` is `pend_rd & en_rd`, gated by the global enable and registered for one cycle. A pending line that is not enabled is not forwarded.
- R9: Global enable. While the global enable is 0, `fwd_out` is all zeros from the next cycle on.
- R10: Edge mode fall. On an edge-mode line, a falling input leaves pending unchanged.
- R11: Configuration port. A write with `cfg_we` is decoded by `cfg_sel`:
  - 0 writes the enable bits;
  - 1 writes the mode bits (1 = edge, 0 = level);
  - 2 writes the global enable from `cfg_wdata` bit 0;
  - 3 has no effect.
  The written values appear on `en_rd`, `mode_rd` and `dist_en_rd` after the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_in | input | NUM_LINES | Raw interrupt inputs, synchronous to clk |
| set_we | input | 1 | Set-pending write strobe |
| set_mask | input | NUM_LINES | Write-one-to-set-pending data |
| clr_we | input | 1 | Clear-pending write strobe |
| clr_mask | input | NUM_LINES | Write-one-to-clear-pending data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 enable, 1 mode, 2 global enable |
| cfg_wdata | input | NUM_LINES | Configuration write data |
| pend_rd | output | NUM_LINES | Pending status read-back |
| en_rd | output | NUM_LINES | Per-line enable read-back |
| mode_rd | output | NUM_LINES | Per-line mode read-back (1 = edge) |
| dist_en_rd | output | 1 | Global enable read-back |
| fwd_out | output | NUM_LINES | Registered pending-and-enabled lines to the CPU interface |

## Verification
The assertions assume that `irq_in` is already synchronous to `clk` and changes at most once per cycle. They also assume that no configuration write changes a line's mode in the same cycle as an edge on that line; the edge property is disabled during configuration writes for that reason. The bench changes all inputs on the falling clock edge and makes mode changes only while inputs are quiet. It checks each result after enough cycles for the two sampling registers and the forwarding register to settle. One forwarding check is placed on the exact cycle.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

  typedef enum logic [1:0] {
    CFG_ENABLE = 2'd0,
    CFG_MODE   = 2'd1,
    CFG_GLOBAL = 2'd2,
    CFG_NONE   = 2'd3
  } cfg_sel_e;

  // Software latch: a set hit always wins over a clear hit.
  function automatic logic latch_next(logic cur, logic set_hit, logic clr_hit);
    return set_hit | (cur & ~clr_hit);
  endfunction

  // Edge capture: a new rise wins over a clear; level-mode lines hold no capture.
  function automatic logic edge_next(logic cur, logic rise, logic clr_hit, logic edge_mode);
    return edge_mode & (rise | (cur & ~clr_hit));
  endfunction

  // Read-back view of one line's pending state.
  function automatic logic pend_view(logic sw, logic cap, logic lvl, logic edge_mode);
    return sw | (edge_mode ? cap : lvl);
  endfunction

  // Rising transition between two consecutive samples.
  function automatic logic rise_of(logic cur, logic prev);
    return cur & ~prev;
  endfunction

endpackage

// File: rtl/irq_edge_sampler.sv
module irq_edge_sampler #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic [NUM_LINES-1:0] lvl_q,
  output logic [NUM_LINES-1:0] rise
);
  import irq_pend_pkg::*;

  logic [NUM_LINES-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      lvl_q  <= irq_in;
      prev_q <= lvl_q;
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_rise
    assign rise[g] = rise_of(lvl_q[g], prev_q[g]);
  end

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_sel,
  input  logic [NUM_LINES-1:0] cfg_wdata,
  output logic [NUM_LINES-1:0] en_q,
  output logic [NUM_LINES-1:0] mode_q,
  output logic                 dist_en_q
);
  import irq_pend_pkg::*;

  cfg_sel_e sel;
  assign sel = cfg_sel_e'(cfg_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      mode_q    <= '0;
      dist_en_q <= 1'b0;
    end else if (cfg_we) begin
      case (sel)
        CFG_ENABLE: en_q      <= cfg_wdata;
        CFG_MODE:   mode_q    <= cfg_wdata;
        CFG_GLOBAL: dist_en_q <= cfg_wdata[0];
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/irq_pend_core.sv
module irq_pend_core #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] set_hit,
  input  logic [NUM_LINES-1:0] clr_hit,
  input  logic [NUM_LINES-1:0] rise,
  input  logic [NUM_LINES-1:0] lvl,
  input  logic [NUM_LINES-1:0] edge_mode,
  output logic [NUM_LINES-1:0] sw_latch,
  output logic [NUM_LINES-1:0] edge_cap,
  output logic [NUM_LINES-1:0] pend
);
  import irq_pend_pkg::*;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sw_latch[g] <= 1'b0;
        edge_cap[g] <= 1'b0;
      end else begin
        sw_latch[g] <= latch_next(sw_latch[g], set_hit[g], clr_hit[g]);
        edge_cap[g] <= edge_next(edge_cap[g], rise[g], clr_hit[g], edge_mode[g]);
      end
    end
    assign pend[g] = pend_view(sw_latch[g], edge_cap[g], lvl[g], edge_mode[g]);
  end

endmodule

// File: rtl/irq_fwd_stage.sv
module irq_fwd_stage #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pend,
  input  logic [NUM_LINES-1:0] en,
  input  logic                 dist_en,
  output logic [NUM_LINES-1:0] fwd
);
  logic [NUM_LINES-1:0] gate;
  assign gate = {NUM_LINES{dist_en}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fwd <= '0;
    else        fwd <= pend & en & gate;
  end

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 set_we,
  input  logic [NUM_LINES-1:0] set_mask,
  input  logic                 clr_we,
  input  logic [NUM_LINES-1:0] clr_mask,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_sel,
  input  logic [NUM_LINES-1:0] cfg_wdata,
  output logic [NUM_LINES-1:0] pend_rd,
  output logic [NUM_LINES-1:0] en_rd,
  output logic [NUM_LINES-1:0] mode_rd,
  output logic                 dist_en_rd,
  output logic [NUM_LINES-1:0] fwd_out
);

  // Named internal events for the checker
  logic [NUM_LINES-1:0] lvl_q;
  logic [NUM_LINES-1:0] edge_rise;
  logic [NUM_LINES-1:0] set_hit;
  logic [NUM_LINES-1:0] clr_hit;
  logic [NUM_LINES-1:0] sw_latch;
  logic [NUM_LINES-1:0] edge_cap;

  assign set_hit = set_we ? set_mask : '0;
  assign clr_hit = clr_we ? clr_mask : '0;

  irq_edge_sampler #(.NUM_LINES(NUM_LINES)) u_sampler (
    .clk   (clk),
    .rst_n (rst_n),
    .irq_in(irq_in),
    .lvl_q (lvl_q),
    .rise  (edge_rise)
  );

  irq_cfg_regs #(.NUM_LINES(NUM_LINES)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .en_q     (en_rd),
    .mode_q   (mode_rd),
    .dist_en_q(dist_en_rd)
  );

  irq_pend_core #(.NUM_LINES(NUM_LINES)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_hit  (set_hit),
    .clr_hit  (clr_hit),
    .rise     (edge_rise),
    .lvl      (lvl_q),
    .edge_mode(mode_rd),
    .sw_latch (sw_latch),
    .edge_cap (edge_cap),
    .pend     (pend_rd)
  );

  irq_fwd_stage #(.NUM_LINES(NUM_LINES)) u_fwd (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend   (pend_rd),
    .en     (en_rd),
    .dist_en(dist_en_rd),
    .fwd    (fwd_out)
  );

endmodule

// File: rtl/irq_pend_bank_chk.sv
module irq_pend_bank_chk #(
  parameter int NUM_LINES = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 set_we,
  input logic [NUM_LINES-1:0] set_mask,
  input logic                 clr_we,
  input logic [NUM_LINES-1:0] clr_mask,
  input logic                 cfg_we,
  input logic [NUM_LINES-1:0] pend_rd,
  input logic [NUM_LINES-1:0] en_rd,
  input logic [NUM_LINES-1:0] mode_rd,
  input logic                 dist_en_rd,
  input logic [NUM_LINES-1:0] fwd_out,
  input logic [NUM_LINES-1:0] edge_rise,
  input logic [NUM_LINES-1:0] sw_latch
);

  AST_FWD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_out == $past(pend_rd & en_rd & {NUM_LINES{dist_en_rd}})); // R8

  AST_DIST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !dist_en_rd |=> fwd_out == '0); // R9

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> (pend_rd & $past(set_mask)) == $past(set_mask)); // R7

  AST_EDGE_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && |(edge_rise & mode_rd)) |=>
      (pend_rd & $past(edge_rise & mode_rd)) == $past(edge_rise & mode_rd)); // R2

  AST_SW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> (pend_rd & $past(sw_latch)) == $past(sw_latch)); // R4

  AST_CLR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> (sw_latch & $past(clr_mask)) == '0); // R5

endmodule

bind irq_pend_bank irq_pend_bank_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .set_we    (set_we),
  .set_mask  (set_mask),
  .clr_we    (clr_we),
  .clr_mask  (clr_mask),
  .cfg_we    (cfg_we),
  .pend_rd   (pend_rd),
  .en_rd     (en_rd),
  .mode_rd   (mode_rd),
  .dist_en_rd(dist_en_rd),
  .fwd_out   (fwd_out),
  .edge_rise (edge_rise),
  .sw_latch  (sw_latch)
);

// File: tb/test_irq_pend_bank.sv
module test_irq_pend_bank;
  localparam int NL = 32;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG_CYCLES = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] irq_in = '0;
  logic          set_we = 1'b0;
  logic [NL-1:0] set_mask = '0;
  logic          clr_we = 1'b0;
  logic [NL-1:0] clr_mask = '0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = 2'd0;
  logic [NL-1:0] cfg_wdata = '0;
  logic [NL-1:0] pend_rd, en_rd, mode_rd, fwd_out;
  logic          dist_en_rd;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles++;

  irq_pend_bank #(.NUM_LINES(NL)) i_irq_pend_bank (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .set_we(set_we), .set_mask(set_mask),
    .clr_we(clr_we), .clr_mask(clr_mask),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .pend_rd(pend_rd), .en_rd(en_rd), .mode_rd(mode_rd),
    .dist_en_rd(dist_en_rd), .fwd_out(fwd_out)
  );

  task automatic check(input string req, input logic [NL-1:0] act, input logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [NL-1:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic write_pend(input logic sw, input logic [NL-1:0] sm,
                            input logic cw, input logic [NL-1:0] cm);
    set_we = sw; set_mask = sm; clr_we = cw; clr_mask = cm;
    @(negedge clk);
    set_we = 1'b0; set_mask = '0; clr_we = 1'b0; clr_mask = '0;
  endtask

  task automatic clean_up();
    irq_in = '0;
    settle(3);
    write_pend(1'b0, '0, 1'b1, '1);
    settle(2);
  endtask

  task automatic t_reset();
    check("R1 pend", pend_rd, '0);
    check("R1 en", en_rd, '0);
    check("R1 mode level", mode_rd, '0);
    check("R1 global", {{(NL-1){1'b0}}, dist_en_rd}, '0);
    check("R1 fwd", fwd_out, '0);
  endtask

  task automatic t_config();
    cfg_write(2'd0, 32'h0000_00F0);
    check("R11 enable", en_rd, 32'h0000_00F0);
    cfg_write(2'd1, 32'h0000_0001);
    check("R11 mode", mode_rd, 32'h0000_0001);
    cfg_write(2'd3, 32'hFFFF_FFFF);
    check("R11 sel3 no effect", en_rd ^ mode_rd, 32'h0000_00F1);
    cfg_write(2'd2, 32'h0000_0001);
    check("R11 global", {{(NL-1){1'b0}}, dist_en_rd}, 32'h1);
    cfg_write(2'd2, 32'h0000_0000);
    cfg_write(2'd0, 32'h0);
  endtask

  task automatic t_edge_line();
    // line 0 in edge mode, disabled
    irq_in[0] = 1'b1;
    settle(3);
    check("R2 edge pend while disabled", pend_rd, 32'h1);
    check("R8 disabled not forwarded", fwd_out, '0);
    irq_in[0] = 1'b0;
    settle(3);
    check("R10 edge fall keeps pend", pend_rd, 32'h1);
    write_pend(1'b0, '0, 1'b1, 32'h1);
    settle(1);
    check("R5 clear edge capture", pend_rd, '0);
    clean_up();
  endtask

  task automatic t_level_line();
    irq_in[1] = 1'b1;
    settle(2);
    check("R3 level high pending", pend_rd, 32'h2);
    irq_in[1] = 1'b0;
    settle(2);
    check("R3 level fall clears", pend_rd, '0);
    clean_up();
  endtask

  task automatic t_sw_hold();
    irq_in[2] = 1'b1;
    settle(2);
    write_pend(1'b1, 32'h4, 1'b0, '0);
    irq_in[2] = 1'b0;
    settle(3);
    check("R4 sw latch holds after fall", pend_rd, 32'h4);
    irq_in[2] = 1'b1;
    settle(2);
    write_pend(1'b0, '0, 1'b1, 32'h4);
    settle(1);
    check("R5 level high stays after clear", pend_rd, 32'h4);
    irq_in[2] = 1'b0;
    settle(2);
    check("R5 cleared once input low", pend_rd, '0);
    clean_up();
  endtask

  task automatic t_zero_mask();
    write_pend(1'b1, 32'h8, 1'b0, '0);
    write_pend(1'b1, 32'h0, 1'b1, 32'h0);
    settle(1);
    check("R6 zero masks no effect", pend_rd, 32'h8);
    write_pend(1'b1, 32'h8, 1'b1, 32'h10);
    check("R6 clear of other bit no effect", pend_rd, 32'h8);
    clean_up();
  endtask

  task automatic t_set_wins();
    write_pend(1'b1, 32'h10, 1'b1, 32'h10);
    settle(1);
    check("R7 set wins", pend_rd, 32'h10);
    clean_up();
  endtask

  task automatic t_forward();
    write_pend(1'b1, 32'h30, 1'b0, '0);
    cfg_write(2'd2, 32'h1);
    // enable written at posedge k; fwd registered at k+1
    cfg_write(2'd0, 32'h10);
    check("R8 fwd not yet", fwd_out, '0);
    settle(1);
    check("R8 fwd after one cycle", fwd_out, 32'h10);
    cfg_write(2'd2, 32'h0);
    settle(1);
    check("R9 global off", fwd_out, '0);
    check("R9 pend kept", pend_rd, 32'h30);
    cfg_write(2'd0, 32'h0);
    clean_up();
  endtask

  initial begin : watchdog
    wait (cycles >= WATCHDOG_CYCLES || done);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <%0d cycles", cycles, WATCHDOG_CYCLES);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(1);
    t_reset();
    t_config();
    t_edge_line();
    cfg_write(2'd1, 32'h0);
    t_level_line();
    t_sw_hold();
    t_zero_mask();
    t_set_wins();
    t_forward();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule